// File: doc/BRIEF.md
# PTP Event Timestamp Snapshot Filter

This block sits on the receive byte stream of an Ethernet port, after MAC framing and CRC stripping. It recognises frames that carry Precision Time Protocol messages directly over Ethernet. For each such frame it decides whether the local time value belongs to that frame. The free-running timestamp counter is latched on the first byte of every frame. When the frame ends, the latched value is either released together with the decoded message type, or it is dropped.

The decision comes from a small per-frame configuration. A 2-bit snapshot class, an event-only bit and a master-role bit index a fixed selection table of PTP message types. A mask-enable bit replaces that table with a 16-bit accept mask, which software sets with one bit per message-type code. The configuration is sampled with the first byte of a frame. A configuration change therefore takes effect from the next frame on.

Bytes are qualified by `rx_valid`. `rx_sof` and `rx_eof` flag the first and last byte of a frame and count only on a valid byte. Bytes between an end of frame and the next start of frame are ignored.

Top module: `ptp_snap_filter`

## Requirements
- R1: While reset is asserted (synchronous, active low), the outputs go to zero on the next clock edge: `ts_valid`=0, `ts_value`=0, `ts_msg_type`=0.
- R2: `ts_value` carries the `ts_counter` value that was present on the frame's start byte. It holds its value between pulses.
- R3: `ts_valid` is a single-cycle pulse in the cycle after the end-of-frame byte, with `ts_msg_type` set to the frame's message type. It is raised only for a PTP frame whose type is selected.
- R4: A frame is PTP when bytes 12-13 hold 0x88F7. It is also PTP when bytes 12-13 hold 0x8100 and bytes 16-17 hold 0x88F7 (one tag only). The message type is then the low nibble of byte 14 or byte 18 respectively. Any other frame gives no pulse.
- R5: Message codes: Sync=0, Delay_Req=1, Pdelay_Req=2, Pdelay_Resp=3, Follow_Up=8, Delay_Resp=9. With class 00, event-only 0 selects Sync, Follow_Up, Delay_Req and Delay_Resp. With event-only 1 it selects only Sync when master=0, and only Delay_Req when master=1.
- R6: With class 01, event-only 0 selects Sync, Follow_Up, Delay_Req, Delay_Resp, Pdelay_Req and Pdelay_Resp. With event-only 1 it selects Pdelay_Req and Pdelay_Resp, plus Sync when master=0 or Delay_Req when master=1.
- R7: Class 10 selects Sync and Delay_Req. Class 11 selects Pdelay_Req and Pdelay_Resp. In both classes the event-only and master bits have no effect.
- R8: The table never selects codes 0xA (Pdelay_Resp_Follow_Up), 0xB (Announce), 0xC (Signaling) or 0xD (Management).
- R9: With mask-enable 1, a message of code n is selected exactly when bit n of the accept mask is 1, and the table is not consulted.
- R10: All configuration inputs are sampled on the start byte. Changes later in the same frame do not affect that frame.
- R11: A frame whose end byte arrives before its message-type byte gives no pulse. A frame whose end byte is the message-type byte is decided normally.
- R12: A new start byte before an end byte abandons the open frame without a pulse and starts a fresh frame with a fresh latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte valid |
| rx_sof | input | 1 | First byte of frame (with rx_valid) |
| rx_eof | input | 1 | Last byte of frame (with rx_valid) |
| rx_data | input | 8 | Frame byte |
| ts_counter | input | TS_W | Free-running time value |
| cfg_snap_type | input | 2 | Snapshot class selecting a table column |
| cfg_event_only | input | 1 | Narrow the class to event messages |
| cfg_master | input | 1 | Role bit choosing Sync or Delay_Req side |
| cfg_mask_en | input | 1 | Use accept mask instead of table |
| cfg_accept_mask | input | 16 | One accept bit per message code |
| ts_valid | output | 1 | One-cycle release pulse |
| ts_value | output | TS_W | Latched time of the released frame |
| ts_msg_type | output | 4 | Message code of the released frame |

## Verification
A byte-index or EtherType tracking error appears on the first pulse that is missing or extra, in the cycle after the affected frame's end byte. It hits tagged frames or short frames first. A wrong selection entry shows only for its own class, role and message combination, so every column of the table is driven with selected and rejected codes. A stale latch of time or configuration shows up as a wrong `ts_value` on the next released frame, or as a pulse decided by the previous frame's settings. Frames that change configuration mid-frame or are cut short expose this.

// File: rtl/ptp_snap_pkg.sv
// Package: shared types for the PTP snapshot filter.
// Holds message-type codes, snapshot class codes and the per-frame
// configuration record latched at start of frame.
package ptp_snap_pkg;

    typedef enum logic [3:0] {
        MSG_SYNC      = 4'h0,
        MSG_DLY_REQ   = 4'h1,
        MSG_PDLY_REQ  = 4'h2,
        MSG_PDLY_RESP = 4'h3,
        MSG_FOLLOW_UP = 4'h8,
        MSG_DLY_RESP  = 4'h9,
        MSG_PDLY_FU   = 4'hA,
        MSG_ANNOUNCE  = 4'hB,
        MSG_SIGNAL    = 4'hC,
        MSG_MGMT      = 4'hD
    } ptp_msg_e;

    typedef enum logic [1:0] {
        SNAP_E2E_BASIC = 2'b00,
        SNAP_ALL_DELAY = 2'b01,
        SNAP_SYNC_DREQ = 2'b10,
        SNAP_PDELAY    = 2'b11
    } snap_class_e;

    typedef struct packed {
        snap_class_e  snap_class;
        logic         event_only;
        logic         master;
        logic         mask_en;
        logic [15:0]  accept_mask;
    } snap_cfg_t;

    // One-hot accept bit for a message code.
    function automatic logic [15:0] msg_bit(ptp_msg_e m);
        return 16'b1 << m;
    endfunction

endpackage

// File: rtl/ptp_frame_parser.sv
// Module: ptp_frame_parser
// Tracks byte position within a received frame, detects the PTP EtherType
// (directly or behind one VLAN tag) and extracts the message-type nibble.
// Assumes rx_sof/rx_eof are only meaningful with rx_valid; bytes outside a
// frame are ignored. type_known/msg_type include the current byte.
module ptp_frame_parser #(
    parameter logic [15:0] ETYPE_PTP  = 16'h88F7,
    parameter logic [15:0] ETYPE_VLAN = 16'h8100,
    parameter int          ET_IDX     = 12,
    parameter int          TAG_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic [7:0] rx_data,
    output logic       sof_take,
    output logic       eof_take,
    output logic       type_known,
    output logic [3:0] msg_type
);
    localparam int HDR_IDX      = ET_IDX + 2;
    localparam int VLAN_ET_IDX  = ET_IDX + TAG_LEN;
    localparam int VLAN_HDR_IDX = VLAN_ET_IDX + 2;
    localparam int IDX_W        = $clog2(VLAN_HDR_IDX + 2);

    localparam logic [IDX_W-1:0] I_ET_HI   = IDX_W'(ET_IDX);
    localparam logic [IDX_W-1:0] I_ET_LO   = IDX_W'(ET_IDX + 1);
    localparam logic [IDX_W-1:0] I_VET_HI  = IDX_W'(VLAN_ET_IDX);
    localparam logic [IDX_W-1:0] I_VET_LO  = IDX_W'(VLAN_ET_IDX + 1);
    localparam logic [IDX_W-1:0] I_HDR     = IDX_W'(HDR_IDX);
    localparam logic [IDX_W-1:0] I_VHDR    = IDX_W'(VLAN_HDR_IDX);
    localparam logic [IDX_W-1:0] I_MAX     = '1;

    logic             in_frame_q;
    logic [IDX_W-1:0] cnt_q;
    logic [7:0]       et_hi_q;
    logic             vlan_q, ptp_q, have_q;
    logic [3:0]       type_q;

    logic             byte_take;
    logic [IDX_W-1:0] cur_idx;
    logic             vlan_f, ptp_f, have_f;
    logic [15:0]      et_word;
    logic             hdr_now;

    // Decode the current byte's position and frame-scoped flags.
    always_comb begin
        byte_take = rx_valid && (rx_sof || in_frame_q);
        cur_idx   = rx_sof ? '0 : cnt_q;
        vlan_f    = !rx_sof && vlan_q;
        ptp_f     = !rx_sof && ptp_q;
        have_f    = !rx_sof && have_q;
        et_word   = {et_hi_q, rx_data};
        hdr_now   = byte_take && ptp_f && !have_f &&
                    ((!vlan_f && cur_idx == I_HDR) || (vlan_f && cur_idx == I_VHDR));
    end

    assign sof_take   = rx_valid && rx_sof;
    assign eof_take   = byte_take && rx_eof;
    assign type_known = have_f || hdr_now;
    assign msg_type   = hdr_now ? rx_data[3:0] : type_q;

    // Frame membership and saturating byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
        end else if (byte_take) begin
            in_frame_q <= !rx_eof;
            cnt_q      <= (cur_idx == I_MAX) ? cur_idx : cur_idx + 1'b1;
        end
    end

    // Hold the upper EtherType byte until its lower byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            et_hi_q <= '0;
        end else if (byte_take && (cur_idx == I_ET_HI || (vlan_f && cur_idx == I_VET_HI))) begin
            et_hi_q <= rx_data;
        end
    end

    // Classify the frame: tagged, PTP, or neither.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vlan_q <= 1'b0;
            ptp_q  <= 1'b0;
        end else if (byte_take) begin
            if (rx_sof) begin
                vlan_q <= 1'b0;
                ptp_q  <= 1'b0;
            end else if (!vlan_f && cur_idx == I_ET_LO) begin
                if (et_word == ETYPE_PTP)       ptp_q  <= 1'b1;
                else if (et_word == ETYPE_VLAN) vlan_q <= 1'b1;
            end else if (vlan_f && cur_idx == I_VET_LO && et_word == ETYPE_PTP) begin
                ptp_q <= 1'b1;
            end
        end
    end

    // Capture the message-type nibble from the first PTP header byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            type_q <= '0;
        end else if (byte_take) begin
            if (rx_sof) begin
                have_q <= 1'b0;
            end else if (hdr_now) begin
                have_q <= 1'b1;
                type_q <= rx_data[3:0];
            end
        end
    end

endmodule

// File: rtl/ptp_select_table.sv
// Module: ptp_select_table
// Combinational selection: turns the latched snapshot configuration into a
// 16-bit set of accepted message codes (fixed table or software mask) and
// tests the given message code against it. Purely combinational.
module ptp_select_table
    import ptp_snap_pkg::*;
(
    input  snap_cfg_t  cfg,
    input  logic [3:0] msg_type,
    output logic       accept
);
    logic [15:0] tbl_set;
    logic [15:0] eff_set;

    // Build the accepted set for the configured class and role.
    always_comb begin
        tbl_set = '0;
        unique case (cfg.snap_class)
            SNAP_E2E_BASIC: begin
                if (!cfg.event_only)
                    tbl_set = msg_bit(MSG_SYNC) | msg_bit(MSG_DLY_REQ) |
                              msg_bit(MSG_FOLLOW_UP) | msg_bit(MSG_DLY_RESP);
                else
                    tbl_set = cfg.master ? msg_bit(MSG_DLY_REQ) : msg_bit(MSG_SYNC);
            end
            SNAP_ALL_DELAY: begin
                if (!cfg.event_only)
                    tbl_set = msg_bit(MSG_SYNC) | msg_bit(MSG_DLY_REQ) |
                              msg_bit(MSG_FOLLOW_UP) | msg_bit(MSG_DLY_RESP) |
                              msg_bit(MSG_PDLY_REQ) | msg_bit(MSG_PDLY_RESP);
                else
                    tbl_set = msg_bit(MSG_PDLY_REQ) | msg_bit(MSG_PDLY_RESP) |
                              (cfg.master ? msg_bit(MSG_DLY_REQ) : msg_bit(MSG_SYNC));
            end
            SNAP_SYNC_DREQ: tbl_set = msg_bit(MSG_SYNC) | msg_bit(MSG_DLY_REQ);
            SNAP_PDELAY:    tbl_set = msg_bit(MSG_PDLY_REQ) | msg_bit(MSG_PDLY_RESP);
            default:        tbl_set = '0;
        endcase
    end

    // Mask mode bypasses the table entirely.
    always_comb begin
        eff_set = cfg.mask_en ? cfg.accept_mask : tbl_set;
        accept  = eff_set[msg_type];
    end

endmodule

// File: rtl/ptp_ts_capture.sv
// Module: ptp_ts_capture
// Latches the time value and configuration on the start byte, and on the
// end byte releases the latched time for one cycle if the frame's message
// type is known and accepted. Outputs hold between releases.
module ptp_ts_capture
    import ptp_snap_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_take,
    input  logic            eof_take,
    input  logic [TS_W-1:0] ts_counter,
    input  snap_cfg_t       cfg_in,
    input  logic            type_known,
    input  logic            accept,
    input  logic [3:0]      msg_type,
    output snap_cfg_t       cfg_q,
    output logic            ts_valid,
    output logic [TS_W-1:0] ts_value,
    output logic [3:0]      ts_msg_type
);
    logic [TS_W-1:0] ts_lat_q;
    logic            emit;

    assign emit = eof_take && type_known && accept;

    // Snapshot time and configuration on every start byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_lat_q <= '0;
            cfg_q    <= '0;
        end else if (sof_take) begin
            ts_lat_q <= ts_counter;
            cfg_q    <= cfg_in;
        end
    end

    // Present the snapshot for one cycle after a selected frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_valid    <= 1'b0;
            ts_value    <= '0;
            ts_msg_type <= '0;
        end else begin
            ts_valid <= emit;
            if (emit) begin
                ts_value    <= ts_lat_q;
                ts_msg_type <= msg_type;
            end
        end
    end

endmodule

// File: rtl/ptp_snap_filter.sv
// Module: ptp_snap_filter (top)
// Receive-side PTP timestamp snapshot filter. Parses the byte stream,
// selects message types per the latched configuration and releases the
// start-of-frame time for selected frames. Assumes a CRC-checked, framed
// byte stream with rx_sof/rx_eof qualified by rx_valid.
module ptp_snap_filter
    import ptp_snap_pkg::*;
#(
    parameter int          TS_W       = 64,
    parameter logic [15:0] ETYPE_PTP  = 16'h88F7,
    parameter logic [15:0] ETYPE_VLAN = 16'h8100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic            rx_sof,
    input  logic            rx_eof,
    input  logic [7:0]      rx_data,
    input  logic [TS_W-1:0] ts_counter,
    input  logic [1:0]      cfg_snap_type,
    input  logic            cfg_event_only,
    input  logic            cfg_master,
    input  logic            cfg_mask_en,
    input  logic [15:0]     cfg_accept_mask,
    output logic            ts_valid,
    output logic [TS_W-1:0] ts_value,
    output logic [3:0]      ts_msg_type
);
    snap_cfg_t  cfg_in;
    snap_cfg_t  frm_cfg;
    logic       sof_take, eof_take, type_known, accept;
    logic [3:0] msg_type;
    logic       frm_mask_en;
    logic [1:0] frm_snap_type;

    // Pack the configuration pins into the per-frame record.
    always_comb begin
        cfg_in.snap_class  = snap_class_e'(cfg_snap_type);
        cfg_in.event_only  = cfg_event_only;
        cfg_in.master      = cfg_master;
        cfg_in.mask_en     = cfg_mask_en;
        cfg_in.accept_mask = cfg_accept_mask;
    end

    assign frm_mask_en   = frm_cfg.mask_en;
    assign frm_snap_type = frm_cfg.snap_class;

    ptp_frame_parser #(
        .ETYPE_PTP  (ETYPE_PTP),
        .ETYPE_VLAN (ETYPE_VLAN)
    ) u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_data    (rx_data),
        .sof_take   (sof_take),
        .eof_take   (eof_take),
        .type_known (type_known),
        .msg_type   (msg_type)
    );

    ptp_select_table u_select (
        .cfg      (frm_cfg),
        .msg_type (msg_type),
        .accept   (accept)
    );

    ptp_ts_capture #(
        .TS_W (TS_W)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_take    (sof_take),
        .eof_take    (eof_take),
        .ts_counter  (ts_counter),
        .cfg_in      (cfg_in),
        .type_known  (type_known),
        .accept      (accept),
        .msg_type    (msg_type),
        .cfg_q       (frm_cfg),
        .ts_valid    (ts_valid),
        .ts_value    (ts_value),
        .ts_msg_type (ts_msg_type)
    );

endmodule

// File: rtl/ptp_snap_filter_chk.sv
// Module: ptp_snap_filter_chk
// Protocol and selection properties of the snapshot filter, bound to the
// top. Observes ports plus the latched per-frame class and mask bits.
module ptp_snap_filter_chk #(
    parameter int TS_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_valid,
    input logic            rx_eof,
    input logic            ts_valid,
    input logic [TS_W-1:0] ts_value,
    input logic [3:0]      ts_msg_type,
    input logic            frm_mask_en,
    input logic [1:0]      frm_snap_type
);
    AST_PULSE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> $past(rx_valid && rx_eof)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |=> !ts_valid); // R3
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |-> $stable(ts_value)); // R2
    AST_TABLE_NO_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !frm_mask_en) |-> !(ts_msg_type inside {4'hA, 4'hB, 4'hC, 4'hD})); // R8
    AST_CLASS11_PDELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !frm_mask_en && frm_snap_type == 2'b11) |-> (ts_msg_type inside {4'h2, 4'h3})); // R7
    AST_CLASS10_SYNC_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !frm_mask_en && frm_snap_type == 2'b10) |-> (ts_msg_type inside {4'h0, 4'h1})); // R7
endmodule

bind ptp_snap_filter ptp_snap_filter_chk #(.TS_W(TS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_eof        (rx_eof),
    .ts_valid      (ts_valid),
    .ts_value      (ts_value),
    .ts_msg_type   (ts_msg_type),
    .frm_mask_en   (frm_mask_en),
    .frm_snap_type (frm_snap_type)
);

// File: tb/test_ptp_snap_filter.sv
`timescale 1ns/1ps
// Bench: behavioural per-frame reference model compared on every clock,
// plus directed per-frame hit counts and captured-value checks.
module test_ptp_snap_filter;
    localparam int TS_W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]      rx_data = '0;
    logic [TS_W-1:0] ts_ctr = 64'h1000;
    logic [1:0]      cfg_snap_type = '0;
    logic            cfg_event_only = 1'b0, cfg_master = 1'b0, cfg_mask_en = 1'b0;
    logic [15:0]     cfg_accept_mask = '0;
    logic            ts_valid;
    logic [TS_W-1:0] ts_value;
    logic [3:0]      ts_msg_type;

    int    checks = 0, failures = 0;
    bit    cmp_on = 1'b0, done = 1'b0;
    string cur_req = "R3";

    always #2.5 clk = ~clk;
    always @(posedge clk) ts_ctr <= ts_ctr + 64'd3;

    ptp_snap_filter i_ptp_snap_filter (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .ts_counter(ts_ctr),
        .cfg_snap_type(cfg_snap_type), .cfg_event_only(cfg_event_only),
        .cfg_master(cfg_master), .cfg_mask_en(cfg_mask_en),
        .cfg_accept_mask(cfg_accept_mask), .ts_valid(ts_valid),
        .ts_value(ts_value), .ts_msg_type(ts_msg_type)
    );

    // Reference selection written from the requirement text.
    function automatic bit ref_pick(logic [1:0] st, bit ev, bit ms, bit mk,
                                    logic [15:0] mask, logic [3:0] mt);
        if (mk) return mask[mt];
        case (mt)
            4'h0:       return (st == 2'd2) || (st <= 2'd1 && (!ev || !ms));
            4'h1:       return (st == 2'd2) || (st <= 2'd1 && (!ev || ms));
            4'h2, 4'h3: return (st == 2'd1) || (st == 2'd3);
            4'h8, 4'h9: return (st <= 2'd1) && !ev;
            default:    return 1'b0;
        endcase
    endfunction

    // Reference model state.
    logic [7:0]      fq[$];
    bit              m_in = 1'b0;
    logic [TS_W-1:0] m_ts;
    logic [1:0]      m_st;
    bit              m_ev, m_ms, m_mk;
    logic [15:0]     m_mask;
    logic            e_valid = 1'b0;
    logic [TS_W-1:0] e_val = '0;
    logic [3:0]      e_type = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 1'b0; e_val = '0; e_type = '0; m_in = 1'b0; fq.delete();
        end else begin
            e_valid = 1'b0;
            if (rx_valid && (rx_sof || m_in)) begin
                if (rx_sof) begin
                    fq.delete();
                    m_ts = ts_ctr; m_st = cfg_snap_type; m_ev = cfg_event_only;
                    m_ms = cfg_master; m_mk = cfg_mask_en; m_mask = cfg_accept_mask;
                end
                fq.push_back(rx_data);
                m_in = !rx_eof;
                if (rx_eof) begin
                    int hdr;
                    hdr = -1;
                    if (fq.size() >= 14) begin
                        if ({fq[12], fq[13]} == 16'h88F7) hdr = 14;
                        else if ({fq[12], fq[13]} == 16'h8100 && fq.size() >= 18 &&
                                 {fq[16], fq[17]} == 16'h88F7) hdr = 18;
                    end
                    if (hdr >= 0 && fq.size() > hdr) begin
                        if (ref_pick(m_st, m_ev, m_ms, m_mk, m_mask, fq[hdr][3:0])) begin
                            e_valid = 1'b1; e_val = m_ts; e_type = fq[hdr][3:0];
                        end
                    end
                end
            end
        end
    end

    // Cycle compare and pulse monitor.
    int              pulses = 0;
    logic [TS_W-1:0] last_val;
    logic [3:0]      last_type;
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (ts_valid !== e_valid || (e_valid && (ts_value !== e_val || ts_msg_type !== e_type))) begin
                failures++;
                $display("FAIL %s cycle: valid=%0b val=%0h type=%0h expected valid=%0b val=%0h type=%0h",
                         cur_req, ts_valid, ts_value, ts_msg_type, e_valid, e_val, e_type);
            end
            if (ts_valid) begin
                pulses++; last_val = ts_value; last_type = ts_msg_type;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] st, input bit ev, input bit ms,
                           input bit mk, input logic [15:0] mask);
        @(negedge clk);
        cfg_snap_type = st; cfg_event_only = ev; cfg_master = ms;
        cfg_mask_en = mk; cfg_accept_mask = mask;
    endtask

    function automatic logic [7:0] fbyte(int i, logic [15:0] et, logic [15:0] inner, logic [3:0] mt);
        int hdr;
        hdr = (et == 16'h8100) ? 18 : 14;
        if (i == 12) return et[15:8];
        if (i == 13) return et[7:0];
        if (et == 16'h8100 && i == 16) return inner[15:8];
        if (et == 16'h8100 && i == 17) return inner[7:0];
        if (i == hdr) return {4'h1, mt};
        return 8'(i * 37 + 11);
    endfunction

    // Drive one frame and check the number of releases it produced.
    task automatic send_frame(input logic [15:0] et, input logic [15:0] inner,
                              input logic [3:0] mt, input int len, input bit ends,
                              input bit gap, input bit flip, input logic [1:0] flip_to,
                              input int exp_hits, input string req);
        int              p0;
        logic [TS_W-1:0] sof_ts;
        cur_req = req;
        p0 = pulses;
        sof_ts = '0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (flip && i == 5) cfg_snap_type = flip_to;
            if (i == 0) sof_ts = ts_ctr;
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = ends && (i == len - 1);
            rx_data = fbyte(i, et, inner, mt);
            if (gap && i == 3) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0;
                @(negedge clk);
                rx_valid = 1'b1; rx_data = fbyte(i + 1, et, inner, mt);
                i++;
                rx_eof = ends && (i == len - 1);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (2) @(negedge clk);
        check(pulses - p0 == exp_hits, req, "release count", pulses - p0, exp_hits);
        if (exp_hits == 1) begin
            check(last_val == sof_ts, "R2", "latched time", last_val, sof_ts);
            check(last_type == mt, "R3", "message type", last_type, mt);
        end
    endtask

    task automatic ptp(input logic [3:0] mt, input int exp_hits, input string req);
        send_frame(16'h88F7, 16'h0, mt, 40, 1'b1, 1'b0, 1'b0, 2'b00, exp_hits, req);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ts_valid === 1'b0 && ts_value === '0 && ts_msg_type === '0, "R1",
              "reset outputs", {ts_valid, ts_msg_type}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); cmp_on = 1'b1;

        // R5 class 00
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, '0);
        ptp(4'h0, 1, "R5"); ptp(4'h8, 1, "R5"); ptp(4'h2, 0, "R5");
        ptp(4'h9, 1, "R5"); ptp(4'h1, 1, "R5");
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, '0);
        ptp(4'h0, 1, "R5"); ptp(4'h1, 0, "R5");
        set_cfg(2'b00, 1'b1, 1'b1, 1'b0, '0);
        ptp(4'h0, 0, "R5"); ptp(4'h1, 1, "R5");
        // R6 class 01
        set_cfg(2'b01, 1'b0, 1'b0, 1'b0, '0);
        ptp(4'h3, 1, "R6"); ptp(4'hA, 0, "R6"); ptp(4'h9, 1, "R6");
        set_cfg(2'b01, 1'b1, 1'b0, 1'b0, '0);
        ptp(4'h0, 1, "R6"); ptp(4'h1, 0, "R6"); ptp(4'h2, 1, "R6");
        set_cfg(2'b01, 1'b1, 1'b1, 1'b0, '0);
        ptp(4'h0, 0, "R6"); ptp(4'h1, 1, "R6"); ptp(4'h3, 1, "R6");
        // R7 classes 10 and 11
        set_cfg(2'b10, 1'b1, 1'b1, 1'b0, '0);
        ptp(4'h0, 1, "R7"); ptp(4'h1, 1, "R7"); ptp(4'h2, 0, "R7");
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, '0);
        ptp(4'h2, 1, "R7"); ptp(4'h3, 1, "R7"); ptp(4'h0, 0, "R7");
        // R8 general messages never by table
        set_cfg(2'b01, 1'b0, 1'b0, 1'b0, '0);
        ptp(4'hB, 0, "R8"); ptp(4'hC, 0, "R8"); ptp(4'hD, 0, "R8");
        // R9 accept mask
        set_cfg(2'b01, 1'b0, 1'b0, 1'b1, 16'h2800);
        ptp(4'hB, 1, "R9"); ptp(4'hD, 1, "R9"); ptp(4'h0, 0, "R9");
        // R4 EtherType and tag handling (with an idle gap inside one frame)
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, '0);
        send_frame(16'h8100, 16'h88F7, 4'h0, 30, 1'b1, 1'b1, 1'b0, 2'b00, 1, "R4");
        send_frame(16'h0800, 16'h0, 4'h0, 30, 1'b1, 1'b0, 1'b0, 2'b00, 0, "R4");
        send_frame(16'h8100, 16'h0800, 4'h1, 30, 1'b1, 1'b0, 1'b0, 2'b00, 0, "R4");
        send_frame(16'h8100, 16'h8100, 4'h1, 30, 1'b1, 1'b0, 1'b0, 2'b00, 0, "R4");
        // R10 configuration change mid-frame
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, '0);
        send_frame(16'h88F7, 16'h0, 4'h0, 30, 1'b1, 1'b0, 1'b1, 2'b10, 0, "R10");
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, '0);
        send_frame(16'h88F7, 16'h0, 4'h0, 30, 1'b1, 1'b0, 1'b1, 2'b11, 1, "R10");
        // R11 short frames
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, '0);
        send_frame(16'h88F7, 16'h0, 4'h0, 14, 1'b1, 1'b0, 1'b0, 2'b00, 0, "R11");
        send_frame(16'h88F7, 16'h0, 4'h0, 15, 1'b1, 1'b0, 1'b0, 2'b00, 1, "R11");
        send_frame(16'h8100, 16'h88F7, 4'h1, 18, 1'b1, 1'b0, 1'b0, 2'b00, 0, "R11");
        send_frame(16'h8100, 16'h88F7, 4'h1, 19, 1'b1, 1'b0, 1'b0, 2'b00, 1, "R11");
        // R12 abandoned frame then a fresh one
        send_frame(16'h88F7, 16'h0, 4'h0, 16, 1'b0, 1'b0, 1'b0, 2'b00, 0, "R12");
        send_frame(16'h88F7, 16'h0, 4'h1, 20, 1'b1, 1'b0, 1'b0, 2'b00, 1, "R12");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule